// File: doc/BRIEF.md
# Half-Bridge Gate PWM with Deadtime and Duty Trim

This block produces the two gate enables of a half-bridge, one for the low-side switch and one for the high-side switch. A period counter sets the switching period, and a separate deadtime timer holds both enables low between conductions. Each period runs the same four phases in the same order: low-side on, deadtime, high-side on, deadtime. Two period lengths are supported. A short period is used for ignition and a longer one for running, and a mode pin chooses between them. A typical ratio is close to 69 kHz against 39 kHz.

A trim input moves conduction time from the high side to the low side. The period and the deadtime stay fixed, and the high-side on-time has a floor of one tenth of the period. A force-off pin parks both enables low and returns the phase to its start. Every restart therefore begins with the low side, which charges the high-side bootstrap capacitor first.

All controls are plain level pins, with no handshake and no back-pressure. Period, deadtime and trim are taken at a period boundary, so the block never emits a shortened pulse.

Top module: `hb_gate_pwm`

## Requirements
- R1: While reset is held both enables are low. In the first clock after reset is released, or after force_off returns low, the block loads its settings. From the following clock lo_en is the first enable driven high.
- R2: lo_en and hi_en are never high in the same cycle.
- R3: Each of the two gaps in a period lasts exactly dead_len cycles (dead_len at least 1), at every period and trim value.
- R4: One period (low-on, gap, high-on, gap) lasts exactly P cycles. P is run_period when run_mode is 1 and ign_period when run_mode is 0. P must be at least 2*dead_len+2.
- R5: With trim 0, the high-side on-time is floor((P-2*dead_len)/2) and the low-side on-time is P-2*dead_len minus that.
- R6: A trim of t cycles shortens the high-side on-time by t and lengthens the low-side on-time by t, and the period stays the same.
- R7: The trim is clamped so that the high-side on-time never drops below floor(P/10) when the untrimmed on-time is above that floor. Larger trim values give exactly floor(P/10).
- R8: A change of run_mode takes effect as a full switch to the other period at the next period boundary, with no intermediate period length.
- R9: Changes to run_mode, the periods, dead_len or trim during a period have no effect on that period.
- R10: force_off high drives both enables low from the next clock and keeps them low while it stays high. The phase is reset, so the restart begins with the low-side on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_mode | input | 1 | 1 selects run_period, 0 selects ign_period |
| ign_period | input | CNT_W | Ignition period in clocks |
| run_period | input | CNT_W | Run period in clocks |
| dead_len | input | DT_W | Deadtime in clocks (at least 1) |
| trim | input | TRIM_W | Duty trim in clocks moved from high side to low side |
| force_off | input | 1 | Drive both enables low and reset the phase |
| lo_en | output | 1 | Low-side gate enable |
| hi_en | output | 1 | High-side gate enable |

## Verification
Two situations are hard to reach from the ports. The first is a settings change that lands inside a running period, which must only take effect one boundary later. The second is force-off arriving while the high side conducts. The stimulus waits on the enables at the falling clock edge. It changes mode and trim during the first low-side cycle, then measures both that period and the next. Separately, it waits until hi_en is observed high before raising force_off. A sweep over both modes, several deadtimes and trims up to the clamp shows that the floor is reached exactly.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LO   = 3'd1,
    PH_DA   = 3'd2,
    PH_HI   = 3'd3,
    PH_DB   = 3'd4
  } hb_phase_t;
endpackage

// File: rtl/hb_cfg_calc.sv
module hb_cfg_calc #(
  parameter int CNT_W  = 10,
  parameter int DT_W   = 5,
  parameter int TRIM_W = 6
) (
  input  logic              run_mode,
  input  logic [CNT_W-1:0]  ign_period,
  input  logic [CNT_W-1:0]  run_period,
  input  logic [DT_W-1:0]   dead_len,
  input  logic [TRIM_W-1:0] trim,
  output logic [CNT_W-1:0]  nx_period,
  output logic [DT_W-1:0]   nx_dead,
  output logic [CNT_W-1:0]  nx_lo
);
  localparam int FLOOR_DIV = 10;

  logic [CNT_W-1:0] span, base, flr, room, te, hi_len, trim_x;

  always_comb begin
    nx_period = run_mode ? run_period : ign_period;
    nx_dead   = dead_len;
    span      = nx_period - (CNT_W'(dead_len) << 1);
    base      = span >> 1;
    flr       = nx_period / CNT_W'(FLOOR_DIV);
    room      = (base > flr) ? (base - flr) : '0;
    trim_x    = CNT_W'(trim);
    te        = (trim_x > room) ? room : trim_x;
    hi_len    = base - te;
    nx_lo     = span - hi_len;
    if (base > flr) begin
      assert_hi_floor_R7: assert (hi_len >= flr)
        else $error("high-side on-time below floor");
    end
  end
endmodule

// File: rtl/hb_dead_timer.sv
module hb_dead_timer #(
  parameter int DT_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gap_active,
  input  logic [DT_W-1:0] dead_q,
  output logic            dead_done
);
  logic [DT_W-1:0] dcnt;

  assign dead_done = gap_active && (dcnt == dead_q - DT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) dcnt <= '0;
    else if (gap_active && !dead_done) dcnt <= dcnt + DT_W'(1);
    else dcnt <= '0;
  end

  assert_gap_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gap_active |=> dcnt == '0);
endmodule

// File: rtl/hb_phase_fsm.sv
module hb_phase_fsm
  import hb_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_off,
  input  logic [CNT_W-1:0] nx_period,
  input  logic [DT_W-1:0]  nx_dead,
  input  logic [CNT_W-1:0] nx_lo,
  input  logic             dead_done,
  output hb_phase_t        ph,
  output logic [DT_W-1:0]  dead_q
);
  logic [CNT_W-1:0] cnt, per_q, lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; per_q <= '0; lo_q <= '0; dead_q <= '0;
    end else if (force_off) begin
      ph <= PH_IDLE; cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          ph <= PH_LO; cnt <= '0;
          per_q <= nx_period; lo_q <= nx_lo; dead_q <= nx_dead;
        end
        PH_LO: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == lo_q - CNT_W'(1)) ph <= PH_DA;
        end
        PH_DA: begin
          cnt <= cnt + CNT_W'(1);
          if (dead_done) ph <= PH_HI;
        end
        PH_HI: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == per_q - CNT_W'(dead_q) - CNT_W'(1)) ph <= PH_DB;
        end
        PH_DB: begin
          if (dead_done) begin
            ph <= PH_LO; cnt <= '0;
            per_q <= nx_period; lo_q <= nx_lo; dead_q <= nx_dead;
          end else cnt <= cnt + CNT_W'(1);
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assert_wrap_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DB && dead_done) |-> cnt == per_q - CNT_W'(1));
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_LO || ph == PH_DA || ph == PH_HI) |=>
      ($stable(per_q) && $stable(lo_q) && $stable(dead_q)));
  assert_lo_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && !force_off) |=> ph == PH_LO);
  assert_hi_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_HI && $past(ph) != PH_HI) |-> $past(ph) == PH_DA);
endmodule

// File: rtl/hb_gate_pwm.sv
module hb_gate_pwm
  import hb_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DT_W   = 5,
  parameter int TRIM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_mode,
  input  logic [CNT_W-1:0]  ign_period,
  input  logic [CNT_W-1:0]  run_period,
  input  logic [DT_W-1:0]   dead_len,
  input  logic [TRIM_W-1:0] trim,
  input  logic              force_off,
  output logic              lo_en,
  output logic              hi_en
);
  logic [CNT_W-1:0] nx_period, nx_lo;
  logic [DT_W-1:0]  nx_dead, dead_q;
  logic             dead_done, gap_active;
  hb_phase_t        ph;

  hb_cfg_calc #(.CNT_W(CNT_W), .DT_W(DT_W), .TRIM_W(TRIM_W)) u_calc (
    .run_mode(run_mode), .ign_period(ign_period), .run_period(run_period),
    .dead_len(dead_len), .trim(trim),
    .nx_period(nx_period), .nx_dead(nx_dead), .nx_lo(nx_lo)
  );

  hb_phase_fsm #(.CNT_W(CNT_W), .DT_W(DT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .force_off(force_off),
    .nx_period(nx_period), .nx_dead(nx_dead), .nx_lo(nx_lo),
    .dead_done(dead_done), .ph(ph), .dead_q(dead_q)
  );

  assign gap_active = (ph == PH_DA) || (ph == PH_DB);

  hb_dead_timer #(.DT_W(DT_W)) u_dead (
    .clk(clk), .rst_n(rst_n), .gap_active(gap_active),
    .dead_q(dead_q), .dead_done(dead_done)
  );

  assign lo_en = (ph == PH_LO);
  assign hi_en = (ph == PH_HI);

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_en && hi_en));
  assert_kill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (!lo_en && !hi_en));
endmodule

// File: tb/sim_hb_gate_pwm.sv
module sim_hb_gate_pwm;
  localparam int CLK_P  = 10;
  localparam int CNT_W  = 10;
  localparam int DT_W   = 5;
  localparam int TRIM_W = 6;
  localparam int P_IGN  = 20;
  localparam int P_RUN  = 36;

  logic clk = 1'b0;
  logic rst_n, run_mode, force_off, lo_en, hi_en;
  logic [CNT_W-1:0] ign_period, run_period;
  logic [DT_W-1:0] dead_len;
  logic [TRIM_W-1:0] trim;
  int total = 0, bad = 0, overlap_n = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  hb_gate_pwm #(.CNT_W(CNT_W), .DT_W(DT_W), .TRIM_W(TRIM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .ign_period(ign_period),
    .run_period(run_period), .dead_len(dead_len), .trim(trim),
    .force_off(force_off), .lo_en(lo_en), .hi_en(hi_en)
  );

  always @(negedge clk) if (lo_en && hi_en) overlap_n++;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expect_len(int p, int d, int t, output int lo, output int hi);
    int base, fl, room, te;
    base = (p - 2*d) / 2;
    fl = p / 10;
    room = (base > fl) ? base - fl : 0;
    te = (t > room) ? room : t;
    hi = base - te;
    lo = p - 2*d - hi;
  endfunction

  task automatic measure(output int a, output int g1, output int b, output int g2);
    a = 0; g1 = 0; b = 0; g2 = 0;
    while (lo_en && !hi_en && a < 600) begin a++; @(negedge clk); end
    while (!lo_en && !hi_en && g1 < 600) begin g1++; @(negedge clk); end
    while (hi_en && !lo_en && b < 600) begin b++; @(negedge clk); end
    while (!lo_en && !hi_en && g2 < 600) begin g2++; @(negedge clk); end
  endtask

  task automatic restart();
    force_off = 1'b1;
    @(negedge clk);
    chk("R10 both low on force_off", int'(lo_en) + int'(hi_en), 0);
    force_off = 1'b0;
    @(negedge clk);
    chk("R10 restart lo first", int'(lo_en), 1);
    chk("R1 hi low at restart", int'(hi_en), 0);
  endtask

  task automatic check_period(int p, int d, int t);
    int a, g1, b, g2, elo, ehi;
    expect_len(p, d, t, elo, ehi);
    measure(a, g1, b, g2);
    if (t == 0) begin
      chk("R5 lo on-time", a, elo);
      chk("R5 hi on-time", b, ehi);
    end else if (ehi == p / 10) begin
      chk("R7 lo on-time clamped", a, elo);
      chk("R7 hi at floor", b, ehi);
    end else begin
      chk("R6 lo on-time", a, elo);
      chk("R6 hi on-time", b, ehi);
    end
    chk("R3 first gap", g1, d);
    chk("R3 second gap", g2, d);
    chk("R4 period", a + g1 + b + g2, p);
  endtask

  initial begin
    rst_n = 1'b0; force_off = 1'b0; run_mode = 1'b0;
    ign_period = CNT_W'(P_IGN); run_period = CNT_W'(P_RUN);
    dead_len = DT_W'(2); trim = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset lo", int'(lo_en), 0);
    chk("R1 reset hi", int'(hi_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lo first after reset", int'(lo_en), 1);
    check_period(P_IGN, 2, 0);

    for (int m = 0; m < 2; m++) begin
      for (int d = 1; d <= 3; d++) begin
        for (int k = 0; k < 16; k++) begin
          int t;
          t = (k == 15) ? 63 : k;
          run_mode = m[0]; dead_len = DT_W'(d); trim = TRIM_W'(t);
          restart();
          check_period(m ? P_RUN : P_IGN, d, t);
        end
      end
    end

    // R8 and R9: change mode and trim inside the first low-side cycle
    run_mode = 1'b0; dead_len = DT_W'(2); trim = '0;
    restart();
    run_mode = 1'b1; trim = TRIM_W'(4);
    check_period(P_IGN, 2, 0);   // R9 current period unaffected
    begin
      int a, g1, b, g2, elo, ehi;
      expect_len(P_RUN, 2, 4, elo, ehi);
      measure(a, g1, b, g2);
      chk("R8 full switch to run period", a + g1 + b + g2, P_RUN);
      chk("R8 trimmed hi after switch", b, ehi);
    end

    // R10: force_off while the high side conducts
    begin
      int guard = 0;
      while (!hi_en && guard < 200) begin guard++; @(negedge clk); end
      chk("R10 reached high-side phase", int'(hi_en), 1);
      force_off = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk("R10 held low", int'(lo_en) + int'(hi_en), 0);
      end
      force_off = 1'b0;
      @(negedge clk);
      chk("R10 restart with low side", int'(lo_en), 1);
      check_period(P_RUN, 2, 4);
    end

    chk("R2 no overlap cycles", overlap_n, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule